// File: doc/BRIEF.md
# Age-Priority Result Bus Arbiter

This block sits between a set of functional units and a pair of shared result buses. Every cycle, any unit that holds a finished result raises its request line. The arbiter chooses at most two of those units and gives each one a bus. It also tells each winner which of the two buses it owns. Requests that have waited longer rank above fresh ones, so no unit is locked out. When several waiting units have the same age, the lower unit number wins.

A unit that loses keeps its request raised. For as long as it loses, the arbiter drives that unit's busy line, and the issue logic must hold back new work for the unit until it wins. Grants, bus selects and busy lines are pure combinational functions of the current requests and the stored request ages. The only state is one small age counter per unit. A counter moves one step per cycle of waiting and clears in the cycle its unit is granted or drops its request.

Top module: `rba_result_arb`

## Requirements
- R1: After reset every age counter is zero, and while no unit requests, every grant, bus select and busy output is 0.
- R2: In each cycle the number of grants is the smaller of two and the number of requesting units.
- R3: The bus-0 winner is the best-ranked requester. Ranking is by larger age first, then by lower unit index. The bus-1 winner is the best-ranked of the remaining requesters. bus_sel_o is 0 for a unit on bus 0 and 1 for a unit on bus 1. bus_sel_o is 0 for any unit that is not granted.
- R4: Each bus has at most one owner per cycle, and no unit is given both buses.
- R5: A grant is never given to a unit whose request is low.
- R6: busy_o of a unit is 1 exactly when that unit requests and is not granted in that cycle.
- R7: A unit's age is 0 in the cycle its request first rises. The age rises by one after each cycle in which the unit requests and is not granted. It returns to 0 after a cycle in which the unit is granted or does not request. Because of this, a unit that has waited beats a lower-index unit that has just raised its request.
- R8: Among requesters of equal age, the lower unit index takes the earlier bus.
- R9: A unit that keeps requesting is busy for no more than (NUM_UNITS-1)/2 consecutive cycles, which is 2 with six units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the age counters |
| req_i | input | NUM_UNITS | Per-unit request: the unit holds a result for a bus |
| gnt_o | output | NUM_UNITS | Per-unit grant for this cycle |
| bus_sel_o | output | NUM_UNITS | Per-unit bus choice for a granted unit (0 = bus 0, 1 = bus 1) |
| busy_o | output | NUM_UNITS | Per-unit stall: requesting but not granted |

## Verification
The bench first applies all six requests at once. This brings out the equal-age tie: a design that breaks ties the wrong way puts a high-index unit on bus 0 or swaps the two buses. A later pattern lets two waiting high-index units compete with a freshly raised unit 0. A design that ignores age, or clears the counter late, grants unit 0 there and leaves a waiting unit stuck. Another pattern drops a waiting request and raises it again. This shows that the age restarts from zero; a design that keeps the stale age wins a grant it should not get. A long pseudo-random run holds every busy unit's request high, which exposes any wait that runs past two cycles and any cycle with a missing or extra grant.

// File: rtl/rba_pkg.sv
package rba_pkg;

  // Bus identifiers as driven on bus_sel_o.
  typedef enum logic {
    RBA_BUS0 = 1'b0,
    RBA_BUS1 = 1'b1
  } rba_bus_e;

  // Number of result buses the arbiter serves.
  localparam int RBA_NUM_BUSES = 2;

  // Longest run of lost cycles for a unit that keeps requesting.
  function automatic int rba_max_wait(input int num_units);
    return (num_units - 1) / 2;
  endfunction

  // Next value of one age counter; saturates at age_max.
  function automatic int rba_age_next(input logic req, input logic gnt,
                                      input int age, input int age_max);
    if (!req || gnt) return 0;
    if (age >= age_max) return age_max;
    return age + 1;
  endfunction

  // True when candidate a ranks above candidate b: older first, lower index on a tie.
  function automatic logic rba_outranks(input int age_a, input int idx_a,
                                        input int age_b, input int idx_b);
    if (age_a != age_b) return age_a > age_b;
    return idx_a < idx_b;
  endfunction

endpackage

// File: rtl/rba_age_track.sv
module rba_age_track
  import rba_pkg::*;
#(
  parameter int AGE_W   = 2,
  parameter int AGE_MAX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             gnt_i,
  output logic [AGE_W-1:0] age_o
);

  logic [AGE_W-1:0] age_q;
  logic [AGE_W-1:0] age_d;

  always_comb begin
    age_d = AGE_W'(rba_age_next(req_i, gnt_i, 32'(age_q), AGE_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  assign age_o = age_q;

endmodule

// File: rtl/rba_pick.sv
module rba_pick
  import rba_pkg::*;
#(
  parameter int NUM_UNITS = 6,
  parameter int AGE_W     = 2,
  parameter int IDX_W     = 3
) (
  input  logic [NUM_UNITS-1:0] cand_i,
  input  logic [AGE_W-1:0]     ages_i [NUM_UNITS],
  output logic [NUM_UNITS-1:0] win_oh_o,
  output logic                 win_vld_o,
  output logic [IDX_W-1:0]     win_idx_o
);

  logic [AGE_W-1:0] best_age;

  // Ascending scan: a later unit replaces the holder only when it strictly outranks it.
  always_comb begin
    win_oh_o  = '0;
    win_vld_o = 1'b0;
    win_idx_o = '0;
    best_age  = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (cand_i[i] &&
          (!win_vld_o ||
           rba_outranks(32'(ages_i[i]), i, 32'(best_age), 32'(win_idx_o)))) begin
        win_vld_o   = 1'b1;
        win_idx_o   = IDX_W'(i);
        best_age    = ages_i[i];
        win_oh_o    = '0;
        win_oh_o[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rba_result_arb.sv
module rba_result_arb
  import rba_pkg::*;
#(
  parameter int NUM_UNITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] req_i,
  output logic [NUM_UNITS-1:0] gnt_o,
  output logic [NUM_UNITS-1:0] bus_sel_o,
  output logic [NUM_UNITS-1:0] busy_o
);

  localparam int MAX_WAIT = rba_max_wait(NUM_UNITS);
  localparam int AGE_W    = $clog2(MAX_WAIT + 2);
  localparam int AGE_MAX  = (1 << AGE_W) - 1;
  localparam int IDX_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

  // Named internal events, observed by the bound checker.
  logic [AGE_W-1:0]     age_q [NUM_UNITS];
  logic [NUM_UNITS-1:0] win0_oh;
  logic [NUM_UNITS-1:0] win1_oh;
  logic [NUM_UNITS-1:0] cand1;
  logic                 bus0_vld;
  logic                 bus1_vld;
  logic [IDX_W-1:0]     bus0_idx;
  logic [IDX_W-1:0]     bus1_idx;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_age
    rba_age_track #(
      .AGE_W  (AGE_W),
      .AGE_MAX(AGE_MAX)
    ) u_age (
      .clk  (clk),
      .rst_n(rst_n),
      .req_i(req_i[u]),
      .gnt_i(gnt_o[u]),
      .age_o(age_q[u])
    );
  end

  // First pass: the best-ranked requester takes bus 0.
  rba_pick #(
    .NUM_UNITS(NUM_UNITS),
    .AGE_W    (AGE_W),
    .IDX_W    (IDX_W)
  ) u_pick0 (
    .cand_i   (req_i),
    .ages_i   (age_q),
    .win_oh_o (win0_oh),
    .win_vld_o(bus0_vld),
    .win_idx_o(bus0_idx)
  );

  // Second pass: the bus-0 winner is removed, so no unit can hold both buses.
  assign cand1 = req_i & ~win0_oh;

  rba_pick #(
    .NUM_UNITS(NUM_UNITS),
    .AGE_W    (AGE_W),
    .IDX_W    (IDX_W)
  ) u_pick1 (
    .cand_i   (cand1),
    .ages_i   (age_q),
    .win_oh_o (win1_oh),
    .win_vld_o(bus1_vld),
    .win_idx_o(bus1_idx)
  );

  assign gnt_o     = win0_oh | win1_oh;
  assign bus_sel_o = win1_oh;
  assign busy_o    = req_i & ~gnt_o;

endmodule

// File: rtl/rba_result_arb_chk.sv
module rba_result_arb_chk #(
  parameter int NUM_UNITS = 6,
  parameter int AGE_W     = 2,
  parameter int AGE_MAX   = 3,
  parameter int IDX_W     = 3,
  parameter int MAX_WAIT  = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_UNITS-1:0] req_i,
  input logic [NUM_UNITS-1:0] gnt_o,
  input logic [NUM_UNITS-1:0] bus_sel_o,
  input logic [NUM_UNITS-1:0] busy_o,
  input logic [AGE_W-1:0]     age_q [NUM_UNITS],
  input logic                 bus0_vld,
  input logic                 bus1_vld,
  input logic [IDX_W-1:0]     bus0_idx,
  input logic [IDX_W-1:0]     bus1_idx
);

  a_r2_grant_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt_o) == (($countones(req_i) > 2) ? 2 : $countones(req_i)));

  a_r4_one_owner_per_bus: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gnt_o & bus_sel_o) <= 1) && ($countones(gnt_o & ~bus_sel_o) <= 1));

  a_r5_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0);

  a_r6_busy_partition: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy_o & gnt_o) == '0) && ((busy_o | gnt_o) == req_i));

  a_r3_bus_order: assert property (@(posedge clk) disable iff (!rst_n)
    bus1_vld |-> (bus0_vld && (age_q[bus0_idx] >= age_q[bus1_idx]) &&
                  bus_sel_o[bus1_idx] && !bus_sel_o[bus0_idx]));

  a_r8_tie_low_index: assert property (@(posedge clk) disable iff (!rst_n)
    (bus1_vld && (age_q[bus0_idx] == age_q[bus1_idx])) |-> (bus0_idx < bus1_idx));

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    a_r7_age_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[u] && !gnt_o[u] && (32'(age_q[u]) != AGE_MAX)) |=>
        (age_q[u] == $past(age_q[u]) + 1'b1));

    a_r7_age_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o[u] || !req_i[u]) |=> (age_q[u] == '0));

    a_r9_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
      32'(age_q[u]) <= MAX_WAIT);

    a_r3_loser_not_older: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o[u] |-> (bus1_vld && (age_q[u] <= age_q[bus1_idx])));
  end

endmodule

bind rba_result_arb rba_result_arb_chk #(
  .NUM_UNITS(NUM_UNITS),
  .AGE_W    (AGE_W),
  .AGE_MAX  (AGE_MAX),
  .IDX_W    (IDX_W),
  .MAX_WAIT (MAX_WAIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .gnt_o    (gnt_o),
  .bus_sel_o(bus_sel_o),
  .busy_o   (busy_o),
  .age_q    (age_q),
  .bus0_vld (bus0_vld),
  .bus1_vld (bus1_vld),
  .bus0_idx (bus0_idx),
  .bus1_idx (bus1_idx)
);

// File: tb/rba_result_arb_bench.sv
module rba_result_arb_bench;

  localparam int N        = 6;
  localparam int MAX_WAIT = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] gnt;
  logic [N-1:0] sel;
  logic [N-1:0] busy;

  always #5 clk = ~clk;

  rba_result_arb #(.NUM_UNITS(N)) u_rba_result_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req),
    .gnt_o    (gnt),
    .bus_sel_o(sel),
    .busy_o   (busy)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Scoreboard queues
  logic [N-1:0] exp_gnt_q [$];
  logic [N-1:0] exp_sel_q [$];
  logic [N-1:0] exp_busy_q [$];
  string        tag_q [$];

  // Reference ages kept by the bench
  int m_age [N];
  int busy_run [N];
  logic [N-1:0] last_busy = '0;
  logic [31:0]  rng = 32'h1F2E3D4C;

  task automatic check(input bit ok, input string what, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  // Driver: apply one request vector and push the expected response.
  task automatic drive(input logic [N-1:0] v, input string tag);
    logic [N-1:0] g;
    logic [N-1:0] s;
    int key;
    int best;
    int pick;
    @(negedge clk);
    req = v;
    g = '0;
    s = '0;
    for (int pass = 0; pass < 2; pass++) begin
      best = -1;
      pick = -1;
      for (int i = 0; i < N; i++) begin
        key = m_age[i] * 16 + (15 - i);
        if (v[i] && !g[i] && key > best) begin
          best = key;
          pick = i;
        end
      end
      if (pick >= 0) begin
        g[pick] = 1'b1;
        s[pick] = (pass == 1);
      end
    end
    exp_gnt_q.push_back(g);
    exp_sel_q.push_back(s);
    exp_busy_q.push_back(v & ~g);
    tag_q.push_back(tag);
    last_busy = v & ~g;
    for (int i = 0; i < N; i++) m_age[i] = (v[i] && !g[i]) ? m_age[i] + 1 : 0;
  endtask

  // Monitor: compare after the driver has settled the inputs.
  initial begin
    logic [N-1:0] eg;
    logic [N-1:0] es;
    logic [N-1:0] eb;
    string t;
    int ng;
    int nr;
    forever begin
      @(negedge clk);
      #2;
      if (exp_gnt_q.size() > 0) begin
        eg = exp_gnt_q.pop_front();
        es = exp_sel_q.pop_front();
        eb = exp_busy_q.pop_front();
        t  = tag_q.pop_front();
        check(gnt == eg, {t, " R3 grant"}, gnt, eg);
        check(sel == es, {t, " R3 bus select"}, sel, es);
        check(busy == eb, {t, " R6 busy"}, busy, eb);
        ng = $countones(gnt);
        nr = $countones(req);
        check(ng == ((nr > 2) ? 2 : nr), {t, " R2 grant count"}, gnt, req);
        check($countones(gnt & sel) <= 1 && $countones(gnt & ~sel) <= 1,
              {t, " R4 one owner per bus"}, gnt & sel, '0);
        check((gnt & ~req) == '0, {t, " R5 grant without request"}, gnt & ~req, '0);
        for (int i = 0; i < N; i++) begin
          busy_run[i] = busy[i] ? busy_run[i] + 1 : 0;
          if (busy[i])
            check(busy_run[i] <= MAX_WAIT, {t, " R9 wait bound"},
                  N'(busy_run[i]), N'(MAX_WAIT));
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_age[i] = 0;
      busy_run[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet while held in reset with no requests
    check(gnt == '0 && busy == '0 && sel == '0, "R1 reset outputs", gnt | busy | sel, '0);
    rst_n = 1'b1;
    drive('0, "R1 idle");
    drive('0, "R1 idle");
    drive(6'b000100, "R5 single");
    drive(6'b100000, "R5 single high");
    // R8: all six at equal age; R7 ages build across the burst
    drive(6'b111111, "R8 tie burst");
    drive(6'b111111, "R7 burst aged");
    drive(6'b111111, "R7 burst aged");
    drive(6'b111111, "R9 burst");
    // R7: waiting units 4,5 beat freshly raised unit 0
    drive('0, "R7 gap");
    drive(6'b111111, "R7 setup");
    drive(6'b110001, "R7 aged over fresh");
    drive(6'b000001, "R7 drain");
    // R7: a dropped request restarts at age zero
    drive('0, "R7 gap");
    drive(6'b111111, "R7 setup");
    drive(6'b000011, "R7 drop others");
    drive(6'b111111, "R7 restart zero");
    drive(6'b000110, "R8 equal pair");
    drive(6'b101000, "R3 two requesters");
    // Pseudo-random traffic; busy units keep their requests (R9)
    for (int k = 0; k < 300; k++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      drive(rng[N-1:0] | last_busy, "R3 random");
    end
    drive('0, "R1 idle end");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule